// File: doc/BRIEF.md
# Serial Flash Access Sequencer

This block turns single-word bus reads and writes into complete serial flash transactions. A bus request starts a frame with chip select held low. The frame carries an instruction byte, a 24-bit address, an optional run of dummy clocks and a 32-bit data word. Reads and writes each have their own configuration inputs: opcode, dummy clock count, and lane width for the address and data phases. Reads also set the lane width of the instruction phase. Each phase shifts over one, two or four data lanes.

When the write-enable prefix is switched on, a write first sends a separate one-byte enable command in its own chip-select frame. The real write follows after a gap with chip select high. The control input for this feature is a disable bit, so a zero turns the prefix on. The serial clock is made from the system clock by an internal divider. The external pads are presented as separate output, output-enable and input vectors for the four data lanes.

Top module: `sflash_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, no data lane is driven, and busy and ready are both low.
- R2: Every frame sends, in this order: the opcode (8 bits), the address (24 bits, most significant bit first), the dummy clocks, and the data word (32 bits). A read takes its opcode and its instruction lane width from the read configuration.
- R3: Lane code 0 selects one lane: output on lane 0, input on lane 1. Code 1 selects lanes 1:0 and code 2 (or 3) selects lanes 3:0. On each serial clock the highest lane carries the most significant of the bits sent together. Only the lanes in use are driven.
- R4: A dummy count of N gives exactly N serial clocks with no lane driven. N = 0 leaves out the dummy phase. The count is below 31.
- R5: Read data is sampled on each rising serial clock edge. The assembled 32-bit word appears on `rdata` in the cycle `ready` is high.
- R6: A write sends the write opcode on one lane. It then sends the address and data with the write lane widths, and the data word goes most significant bit first.
- R7: With `wr_wel_dis` = 0, each write is preceded by its own frame of 8 single-lane clocks carrying opcode 0x06. Chip select then stays high for at least one full serial clock period (the divisor, in system cycles) before the write frame. With `wr_wel_dis` = 1, and for every read, there is no such frame.
- R8: With divider code c, the serial clock period is 2*(c+1) system cycles, and its high and low halves are each c+1 cycles. The clock is low whenever chip select is high.
- R9: `busy` is high whenever chip select is low and during the gap after the prefix. `ready` is a one-cycle pulse at completion and is never high together with `busy`.
- R10: During a read data phase no data lane is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Bus request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 24 | Flash byte address |
| wdata | input | 32 | Write data word |
| rdata | output | 32 | Read data word, valid with ready |
| ready | output | 1 | Completion pulse |
| busy | output | 1 | Transaction in progress |
| div_code | input | 4 | Serial clock divisor code (divisor = 2*(code+1)) |
| rd_opcode | input | 8 | Read opcode |
| rd_dummy | input | 5 | Read dummy clock count |
| rd_inst_lanes | input | 2 | Read instruction lane code |
| rd_addr_lanes | input | 2 | Read address lane code |
| rd_data_lanes | input | 2 | Read data lane code |
| wr_opcode | input | 8 | Write opcode |
| wr_dummy | input | 5 | Write dummy clock count |
| wr_addr_lanes | input | 2 | Write address lane code |
| wr_data_lanes | input | 2 | Write data lane code |
| wr_wel_dis | input | 1 | 1 disables the write-enable prefix |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| dq_out | output | 4 | Data lane output values |
| dq_oe | output | 4 | Data lane output enables |
| dq_in | input | 4 | Data lane input values |

## Verification
The assertions assume three things about the inputs. The configuration and divider inputs do not change while `busy` is high. Dummy counts are below 31. A request is held until its `ready` pulse. The bench changes configuration only after an access has returned, uses dummy counts of 0, 3 and 8, and drops `req` at the falling edge where it sees `ready`. The flash model drives `dq_in` from a count of rising serial clock edges. It updates the value only while the clock is high, so each input is stable at the design's sampling point.

// File: rtl/sfseq_pkg.sv
package sfseq_pkg;
  typedef enum logic [1:0] {
    LN_X1 = 2'd0,
    LN_X2 = 2'd1,
    LN_X4 = 2'd2
  } lane_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WEN, ST_GAP, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_DONE
  } seq_st_e;

  localparam logic [7:0] WEN_OPCODE = 8'h06;
endpackage

// File: rtl/sfseq_clkgen.sv
module sfseq_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_code,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             half_done;

  assign half_done = run && (cnt_q == div_code);
  assign rise      = half_done && !sclk_q;
  assign fall      = half_done && sclk_q;
  assign sclk      = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (half_done) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  // R8: divider setting held while the serial clock runs
  a_r8_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(div_code));
endmodule

// File: rtl/sfseq_shifter.sv
module sfseq_shifter
  import sfseq_pkg::*;
#(
  parameter int SR_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SR_W-1:0] load_val,
  input  logic            shift,
  input  lane_e           lane,
  input  logic            drive,
  input  logic            sample,
  input  logic [3:0]      dq_in,
  output logic [3:0]      dq_out,
  output logic [3:0]      dq_oe,
  output logic [SR_W-1:0] rx_word
);
  logic [SR_W-1:0] tx_q, tx_d, rx_q, rx_d;

  always_comb begin
    case (lane)
      LN_X1:   begin dq_out = {3'b000, tx_q[SR_W-1]};      dq_oe = drive ? 4'b0001 : 4'b0000; end
      LN_X2:   begin dq_out = {2'b00, tx_q[SR_W-1 -: 2]};  dq_oe = drive ? 4'b0011 : 4'b0000; end
      default: begin dq_out = tx_q[SR_W-1 -: 4];           dq_oe = drive ? 4'b1111 : 4'b0000; end
    endcase
  end

  always_comb begin
    tx_d = tx_q;
    if (load) begin
      tx_d = load_val;
    end else if (shift) begin
      case (lane)
        LN_X1:   tx_d = tx_q << 1;
        LN_X2:   tx_d = tx_q << 2;
        default: tx_d = tx_q << 4;
      endcase
    end
  end

  always_comb begin
    rx_d = rx_q;
    if (sample) begin
      case (lane)
        LN_X1:   rx_d = {rx_q[SR_W-2:0], dq_in[1]};
        LN_X2:   rx_d = {rx_q[SR_W-3:0], dq_in[1:0]};
        default: rx_d = {rx_q[SR_W-5:0], dq_in};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign rx_word = rx_q;
endmodule

// File: rtl/sfseq_ctrl.sv
module sfseq_ctrl
  import sfseq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 4,
  parameter int DUMMY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [7:0]         rd_op,
  input  logic [DUMMY_W-1:0] rd_dummy,
  input  lane_e              rd_inst_lane,
  input  lane_e              rd_addr_lane,
  input  lane_e              rd_data_lane,
  input  logic [7:0]         wr_op,
  input  logic [DUMMY_W-1:0] wr_dummy,
  input  lane_e              wr_addr_lane,
  input  lane_e              wr_data_lane,
  input  logic               wr_wel_dis,
  input  logic [DIV_W-1:0]   div_code,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  output logic               run,
  output logic               cs_n,
  output logic               busy,
  output logic               ready,
  output logic               ld,
  output logic [DATA_W-1:0]  ld_val,
  output logic               shift,
  output lane_e              lane,
  output logic               drive,
  output logic               sample
);
  localparam int BEAT_W = $clog2(DATA_W + 1) > DUMMY_W ? $clog2(DATA_W + 1) : DUMMY_W;
  localparam int GAP_W  = DIV_W + 1;
  localparam logic [DUMMY_W-1:0] DUMMY_LIMIT = DUMMY_W'(31);

  seq_st_e            st_q, st_d, tgt;
  logic [BEAT_W-1:0]  beats_q, beats_d;
  logic [GAP_W-1:0]   gap_q, gap_d;
  logic               wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               adv, last_beat, capture, wr_sel;
  logic [7:0]         c_op;
  logic [DUMMY_W-1:0] c_dummy;
  lane_e              c_inst, c_addr, c_data;

  function automatic logic [BEAT_W-1:0] beats_for(input int bits, input lane_e l);
    case (l)
      LN_X1:   return BEAT_W'(bits);
      LN_X2:   return BEAT_W'(bits / 2);
      default: return BEAT_W'(bits / 4);
    endcase
  endfunction

  assign wr_sel    = (st_q == ST_IDLE) ? we : wr_q;
  assign c_op      = wr_sel ? wr_op : rd_op;
  assign c_dummy   = wr_sel ? wr_dummy : rd_dummy;
  assign c_inst    = wr_sel ? LN_X1 : rd_inst_lane;
  assign c_addr    = wr_sel ? wr_addr_lane : rd_addr_lane;
  assign c_data    = wr_sel ? wr_data_lane : rd_data_lane;
  assign last_beat = sclk_fall && (beats_q == BEAT_W'(1));
  assign capture   = (st_q == ST_IDLE) && req;

  // phase order
  always_comb begin
    adv = 1'b0;
    tgt = st_q;
    case (st_q)
      ST_IDLE:  if (req) begin adv = 1'b1; tgt = (we && !wr_wel_dis) ? ST_WEN : ST_CMD; end
      ST_WEN:   if (last_beat) begin adv = 1'b1; tgt = ST_GAP; end
      ST_GAP:   if (gap_q == {div_code, 1'b1}) begin adv = 1'b1; tgt = ST_CMD; end
      ST_CMD:   if (last_beat) begin adv = 1'b1; tgt = ST_ADDR; end
      ST_ADDR:  if (last_beat) begin adv = 1'b1; tgt = (c_dummy != '0) ? ST_DUMMY : ST_DATA; end
      ST_DUMMY: if (last_beat) begin adv = 1'b1; tgt = ST_DATA; end
      ST_DATA:  if (last_beat) begin adv = 1'b1; tgt = ST_DONE; end
      default:  begin adv = 1'b1; tgt = ST_IDLE; end
    endcase
  end

  // phase entry: load shifter and beat counter
  always_comb begin
    st_d    = tgt;
    beats_d = beats_q;
    gap_d   = gap_q;
    ld      = 1'b0;
    ld_val  = '0;
    if (run && sclk_fall && beats_q != '0) beats_d = beats_q - 1'b1;
    if (st_q == ST_GAP) gap_d = gap_q + 1'b1;
    if (adv) begin
      case (tgt)
        ST_WEN: begin
          ld = 1'b1; ld_val = {WEN_OPCODE, {(DATA_W-8){1'b0}}}; beats_d = beats_for(8, LN_X1);
        end
        ST_GAP: gap_d = '0;
        ST_CMD: begin
          ld = 1'b1; ld_val = {c_op, {(DATA_W-8){1'b0}}}; beats_d = beats_for(8, c_inst);
        end
        ST_ADDR: begin
          ld = 1'b1; ld_val = {addr_q, {(DATA_W-ADDR_W){1'b0}}}; beats_d = beats_for(ADDR_W, c_addr);
        end
        ST_DUMMY: beats_d = BEAT_W'(c_dummy);
        ST_DATA: begin
          ld = 1'b1; ld_val = wr_q ? wdata_q : '0; beats_d = beats_for(DATA_W, c_data);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_CMD:  lane = c_inst;
      ST_ADDR: lane = c_addr;
      ST_DATA: lane = c_data;
      default: lane = LN_X1;
    endcase
  end

  assign run    = (st_q == ST_WEN) || (st_q == ST_CMD) || (st_q == ST_ADDR) ||
                  (st_q == ST_DUMMY) || (st_q == ST_DATA);
  assign cs_n   = !run;
  assign busy   = run || (st_q == ST_GAP);
  assign ready  = (st_q == ST_DONE);
  assign shift  = sclk_fall;
  assign drive  = (st_q == ST_WEN) || (st_q == ST_CMD) || (st_q == ST_ADDR) ||
                  ((st_q == ST_DATA) && wr_q);
  assign sample = sclk_rise && (st_q == ST_DATA) && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      beats_q <= '0;
      gap_q   <= '0;
    end else begin
      st_q    <= st_d;
      beats_q <= beats_d;
      gap_q   <= gap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (capture) begin
      wr_q    <= we;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  // R9: completion is a single-cycle pulse
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  // R2: configuration held while a transaction is in flight (input assumption)
  a_r2_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({rd_op, rd_dummy, rd_inst_lane, rd_addr_lane,
      rd_data_lane, wr_op, wr_dummy, wr_addr_lane, wr_data_lane, wr_wel_dis, div_code}));
  // R4: dummy count limit at request time (input assumption)
  a_r4_dummy_limit: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (rd_dummy < DUMMY_LIMIT) && (wr_dummy < DUMMY_LIMIT));
  // R7: prefix frame is always followed by the chip-select gap
  a_r7_prefix_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_WEN && st_q != ST_WEN) |-> (cs_n && busy));
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sfseq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 4,
  parameter int DUMMY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               ready,
  output logic               busy,
  input  logic [DIV_W-1:0]   div_code,
  input  logic [7:0]         rd_opcode,
  input  logic [DUMMY_W-1:0] rd_dummy,
  input  logic [1:0]         rd_inst_lanes,
  input  logic [1:0]         rd_addr_lanes,
  input  logic [1:0]         rd_data_lanes,
  input  logic [7:0]         wr_opcode,
  input  logic [DUMMY_W-1:0] wr_dummy,
  input  logic [1:0]         wr_addr_lanes,
  input  logic [1:0]         wr_data_lanes,
  input  logic               wr_wel_dis,
  output logic               cs_n,
  output logic               sclk,
  output logic [3:0]         dq_out,
  output logic [3:0]         dq_oe,
  input  logic [3:0]         dq_in
);
  logic              run, sclk_rise, sclk_fall, ld, shift, drive, sample;
  logic [DATA_W-1:0] ld_val;
  lane_e             lane;

  sfseq_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .div_code(div_code),
    .sclk(sclk), .rise(sclk_rise), .fall(sclk_fall)
  );

  sfseq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .DUMMY_W(DUMMY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rd_op(rd_opcode), .rd_dummy(rd_dummy),
    .rd_inst_lane(lane_e'(rd_inst_lanes)), .rd_addr_lane(lane_e'(rd_addr_lanes)),
    .rd_data_lane(lane_e'(rd_data_lanes)),
    .wr_op(wr_opcode), .wr_dummy(wr_dummy),
    .wr_addr_lane(lane_e'(wr_addr_lanes)), .wr_data_lane(lane_e'(wr_data_lanes)),
    .wr_wel_dis(wr_wel_dis), .div_code(div_code),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .run(run), .cs_n(cs_n), .busy(busy), .ready(ready),
    .ld(ld), .ld_val(ld_val), .shift(shift), .lane(lane), .drive(drive), .sample(sample)
  );

  sfseq_shifter #(.SR_W(DATA_W)) u_sr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .shift(shift),
    .lane(lane), .drive(drive), .sample(sample), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .rx_word(rdata)
  );

  // R8: serial clock parked low outside a frame
  a_r8_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R10: no lane driven while read data is being sampled
  a_r10_rx_released: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (dq_oe == 4'b0000));
  // R3: lanes are driven only inside a chip-select frame
  a_r3_drive_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != 4'b0000) |-> !cs_n);
endmodule

// File: tb/tb_sflash_seq.sv
module tb_sflash_seq;
  logic        clk, rst_n, req, we, ready, busy, cs_n, sclk, wr_wel_dis;
  logic [23:0] addr;
  logic [31:0] wdata, rdata;
  logic [3:0]  div_code, dq_out, dq_oe, dq_in;
  logic [7:0]  rd_opcode, wr_opcode;
  logic [4:0]  rd_dummy, wr_dummy;
  logic [1:0]  rd_inst_lanes, rd_addr_lanes, rd_data_lanes, wr_addr_lanes, wr_data_lanes;

  int total, bad, fr, rises, since, per_last, hi, hi_last, gap, gap_last, viol;
  bit finished;
  logic p_sclk, p_cs;
  logic [3:0] lo [0:3][0:79];
  logic [3:0] le [0:3][0:79];
  int flen [0:3];

  sflash_seq dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .busy(busy), .div_code(div_code),
    .rd_opcode(rd_opcode), .rd_dummy(rd_dummy), .rd_inst_lanes(rd_inst_lanes),
    .rd_addr_lanes(rd_addr_lanes), .rd_data_lanes(rd_data_lanes),
    .wr_opcode(wr_opcode), .wr_dummy(wr_dummy), .wr_addr_lanes(wr_addr_lanes),
    .wr_data_lanes(wr_data_lanes), .wr_wel_dis(wr_wel_dis),
    .cs_n(cs_n), .sclk(sclk), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = !clk;

  function automatic logic [3:0] pat(input int r);
    return 4'((r * 7 + 5) % 16);
  endfunction

  // flash-side model: logs each rising serial edge, drives read data
  always @(negedge clk) begin
    if (rst_n) begin
      since = since + 1;
      if (!cs_n && sclk && !p_sclk) begin
        if (rises < 80) begin lo[fr][rises] = dq_out; le[fr][rises] = dq_oe; end
        rises = rises + 1;
        per_last = since;
        since = 0;
      end
      if (sclk) hi = hi + 1;
      if (!sclk && p_sclk) begin hi_last = hi; hi = 0; end
      if (cs_n && !p_cs) begin flen[fr] = rises; if (fr < 3) fr = fr + 1; rises = 0; end
      if (!cs_n && p_cs) gap_last = gap;
      if (cs_n) gap = gap + 1; else gap = 0;
      if (ready && busy) viol = viol + 1;
      if (cs_n && sclk) viol = viol + 1;
      if (!cs_n && !busy) viol = viol + 1;
      p_sclk = sclk;
      p_cs   = cs_n;
      dq_in  = pat(rises);
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] decode(input int f, input int s, input int nbits, input int w);
    logic [31:0] acc = '0;
    for (int i = 0; i < nbits / w; i++) begin
      case (w)
        1: acc = (acc << 1) | 32'(lo[f][s+i][0]);
        2: acc = (acc << 2) | 32'(lo[f][s+i][1:0]);
        default: acc = (acc << 4) | 32'(lo[f][s+i]);
      endcase
    end
    return acc;
  endfunction

  function automatic logic oe_all(input int f, input int s, input int n, input logic [3:0] m);
    logic ok = 1'b1;
    for (int i = 0; i < n; i++) if (le[f][s+i] !== m) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [31:0] exp_rd(input int s, input int w);
    logic [31:0] acc = '0;
    for (int i = 0; i < 32 / w; i++) begin
      case (w)
        1: acc = (acc << 1) | 32'(pat(s+i)[1]);
        2: acc = (acc << 2) | 32'(pat(s+i)[1:0]);
        default: acc = (acc << 4) | 32'(pat(s+i));
      endcase
    end
    return acc;
  endfunction

  task automatic access(input logic w, input logic [23:0] a, input logic [31:0] d,
                        output logic [31:0] q);
    @(negedge clk);
    fr = 0; rises = 0; viol = 0;
    req = 1'b1; we = w; addr = a; wdata = d;
    do @(negedge clk); while (!ready);
    q = rdata;
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 cs_n", 64'(cs_n), 64'd1);
    chk("R1 sclk", 64'(sclk), 64'd0);
    chk("R1 dq_oe", 64'(dq_oe), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 ready", 64'(ready), 64'd0);
  endtask

  task automatic t_quad_read;
    logic [31:0] q;
    div_code = 4'd0; rd_opcode = 8'h6B; rd_dummy = 5'd8;
    rd_inst_lanes = 2'd0; rd_addr_lanes = 2'd0; rd_data_lanes = 2'd2;
    access(1'b0, 24'h123456, 32'h0, q);
    chk("R7 read has one frame", 64'(fr), 64'd1);
    chk("R2 quad read length", 64'(flen[0]), 64'd48);
    chk("R2 read opcode", 64'(decode(0, 0, 8, 1)), 64'h6B);
    chk("R2 address msb first", 64'(decode(0, 8, 24, 1)), 64'h123456);
    chk("R3 single lane enable", 64'(oe_all(0, 0, 32, 4'b0001)), 64'd1);
    chk("R4 dummy lanes released", 64'(oe_all(0, 32, 8, 4'b0000)), 64'd1);
    chk("R10 read data lanes released", 64'(oe_all(0, 40, 8, 4'b0000)), 64'd1);
    chk("R5 quad read data", 64'(q), 64'(exp_rd(40, 4)));
    chk("R9 busy/ready/cs relation", 64'(viol), 64'd0);
  endtask

  task automatic t_dual_read;
    logic [31:0] q;
    div_code = 4'd2; rd_opcode = 8'hBB; rd_dummy = 5'd0;
    rd_inst_lanes = 2'd1; rd_addr_lanes = 2'd1; rd_data_lanes = 2'd1;
    access(1'b0, 24'hABCDEF, 32'h0, q);
    chk("R4 zero dummy skipped length", 64'(flen[0]), 64'd32);
    chk("R2 dual instruction lane", 64'(decode(0, 0, 8, 2)), 64'hBB);
    chk("R3 dual address", 64'(decode(0, 4, 24, 2)), 64'hABCDEF);
    chk("R3 dual lane enable", 64'(oe_all(0, 0, 16, 4'b0011)), 64'd1);
    chk("R5 dual read data", 64'(q), 64'(exp_rd(16, 2)));
    chk("R8 period for code 2", 64'(per_last), 64'd6);
    chk("R8 high half for code 2", 64'(hi_last), 64'd3);
    chk("R9 busy/ready/cs relation", 64'(viol), 64'd0);
  endtask

  task automatic t_single_read;
    logic [31:0] q;
    div_code = 4'd0; rd_opcode = 8'h0B; rd_dummy = 5'd3;
    rd_inst_lanes = 2'd0; rd_addr_lanes = 2'd0; rd_data_lanes = 2'd0;
    access(1'b0, 24'h00F00F, 32'h0, q);
    chk("R4 three dummy clocks length", 64'(flen[0]), 64'd67);
    chk("R4 dummy lanes released", 64'(oe_all(0, 32, 3, 4'b0000)), 64'd1);
    chk("R5 single read uses lane 1", 64'(q), 64'(exp_rd(35, 1)));
  endtask

  task automatic t_write_wel;
    logic [31:0] q;
    div_code = 4'd1; wr_opcode = 8'h38; wr_dummy = 5'd0;
    wr_addr_lanes = 2'd2; wr_data_lanes = 2'd2; wr_wel_dis = 1'b0;
    access(1'b1, 24'h5A0C3F, 32'hDEADBEEF, q);
    chk("R7 prefix adds frame", 64'(fr), 64'd2);
    chk("R7 prefix length", 64'(flen[0]), 64'd8);
    chk("R7 prefix opcode", 64'(decode(0, 0, 8, 1)), 64'h06);
    chk("R7 prefix single lane", 64'(oe_all(0, 0, 8, 4'b0001)), 64'd1);
    chk("R7 gap at least divisor", 64'(gap_last >= 4), 64'd1);
    chk("R6 write frame length", 64'(flen[1]), 64'd22);
    chk("R6 write opcode single", 64'(decode(1, 0, 8, 1)), 64'h38);
    chk("R3 quad address", 64'(decode(1, 8, 24, 4)), 64'h5A0C3F);
    chk("R6 quad write data", 64'(decode(1, 14, 32, 4)), 64'hDEADBEEF);
    chk("R3 quad lane enable", 64'(oe_all(1, 8, 14, 4'b1111)), 64'd1);
    chk("R8 period for code 1", 64'(per_last), 64'd4);
    chk("R9 busy/ready/cs relation", 64'(viol), 64'd0);
  endtask

  task automatic t_write_nowel;
    logic [31:0] q;
    div_code = 4'd0; wr_opcode = 8'h02; wr_dummy = 5'd0;
    wr_addr_lanes = 2'd0; wr_data_lanes = 2'd0; wr_wel_dis = 1'b1;
    access(1'b1, 24'h800001, 32'h8000_0001, q);
    chk("R7 disabled prefix", 64'(fr), 64'd1);
    chk("R6 single write length", 64'(flen[0]), 64'd64);
    chk("R6 single write opcode", 64'(decode(0, 0, 8, 1)), 64'h02);
    chk("R6 single write data", 64'(decode(0, 32, 32, 1)), 64'h8000_0001);
    chk("R1 idle after access", 64'({cs_n, sclk, busy, ready}), 64'b1000);
  endtask

  initial begin
    finished = 1'b0; total = 0; bad = 0;
    fr = 0; rises = 0; since = 0; per_last = 0; hi = 0; hi_last = 0;
    gap = 0; gap_last = 0; viol = 0; p_sclk = 1'b0; p_cs = 1'b1;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; dq_in = '0;
    div_code = '0; rd_opcode = '0; rd_dummy = '0; rd_inst_lanes = '0;
    rd_addr_lanes = '0; rd_data_lanes = '0; wr_opcode = '0; wr_dummy = '0;
    wr_addr_lanes = '0; wr_data_lanes = '0; wr_wel_dis = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_quad_read();
    t_dual_read();
    t_single_read();
    t_write_wel();
    t_write_nowel();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule